// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps a small set of entries that track outstanding cache misses. Each live entry holds a block address, a secure-space flag, the cycle from which it may be serviced, and an order stamp. The stamp comes from a counter that advances on every allocation. Unused entries form a free pool. An allocation takes the lowest-numbered free entry in the same cycle it is requested. Deallocation returns an entry to the pool.

Two associative searches run in parallel against every entry in a single cycle. The lookup port reports whether any live entry tracks a given block in a given space, and names the oldest such entry. The pending port applies the same match but only to entries whose ready cycle has arrived. Among those it picks the one with the earliest ready cycle. When two entries have the same ready cycle, the older one wins. Misaligned allocations and allocations into a full pool are refused and reported on one-cycle error outputs.

Top module: `mshr_file`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0, and neither search reports a hit.
- R2: An aligned allocation into a non-full pool asserts alloc_gnt_o in the same cycle. It takes the lowest-numbered free entry, and that index is shown on alloc_idx_o.
- R3: An allocation whose address has any nonzero bit among the low OFF_W bits (4 by default, a 16-byte block) is refused. err_misalign_o is 1 for exactly the following cycle.
- R4: A lookup hits only on a live entry whose block address (the address bits above OFF_W) equals the query's block address and whose secure flag equals the query's. The query's offset bits are ignored.
- R5: When several live entries match a lookup, lookup_idx_o names the one allocated earliest, as ranked by its allocation stamp.
- R6: The pending search ignores any entry whose ready cycle is greater than the internal cycle count. The count is 0 at reset and advances by one on every clock.
- R7: Among ready matching entries, the pending search returns the one with the smallest ready cycle. On equal ready cycles it returns the one allocated earliest.
- R8: A deallocation clears the entry at the next clock edge. From the following cycle the entry is free again: it no longer matches, full_o drops, and it can be granted again.
- R9: An aligned allocation while full is refused. If no deallocation arrives in that same cycle, err_overflow_o is 1 for the next cycle. If a deallocation does arrive, the allocation is refused without an error, and the freed entry becomes available one cycle later.
- R10: full_o is 1 exactly when every entry is live, and empty_o is 1 exactly when none is. Both follow the registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_addr_i | input | ADDR_W | Allocation address, must be block aligned |
| alloc_secure_i | input | 1 | Secure-space flag of the allocation |
| alloc_ready_i | input | TIME_W | Cycle from which the new entry is ready |
| alloc_gnt_o | output | 1 | Allocation accepted this cycle |
| alloc_idx_o | output | IDX_W | Entry taken by an accepted allocation |
| lookup_addr_i | input | ADDR_W | Lookup query address |
| lookup_secure_i | input | 1 | Lookup query secure flag |
| lookup_hit_o | output | 1 | Some live entry matches the lookup |
| lookup_idx_o | output | IDX_W | Oldest matching entry |
| pend_addr_i | input | ADDR_W | Pending-search query address |
| pend_secure_i | input | 1 | Pending-search query secure flag |
| pend_hit_o | output | 1 | Some ready entry matches |
| pend_idx_o | output | IDX_W | Earliest-ready matching entry |
| dealloc_valid_i | input | 1 | Release an entry |
| dealloc_idx_i | input | IDX_W | Entry to release |
| full_o | output | 1 | No free entries |
| empty_o | output | 1 | No live entries |
| err_misalign_o | output | 1 | Misaligned allocation seen last cycle |
| err_overflow_o | output | 1 | Allocation into full pool seen last cycle |

## Verification
The hardest case to reach is a pending search in which one candidate has not yet become ready while another, younger entry already has. The stimulus fills two entries for the same block. The first is given a ready cycle about thirty cycles ahead of the bench's own copy of the cycle count. The second is given a ready cycle already in the past. The search must then pick the younger entry, which also checks that the order stamp does not override ready time. After the younger entry is released, the search must miss until the bench has waited past the first entry's ready cycle. The same-cycle release and allocate on a full pool is reached by leaving the table phase with all four entries live.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  localparam int unsigned DEF_ENTRIES = 4;
  localparam int unsigned DEF_ADDR_W  = 16;
  localparam int unsigned DEF_OFF_W   = 4;
  localparam int unsigned DEF_TIME_W  = 16;
  localparam int unsigned DEF_ORDER_W = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mshr_free_pick.sv
module mshr_free_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     busy_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_oldest_sel.sv
// Picks the matching lane with the smallest key; keys are distinct among live lanes.
module mshr_oldest_sel #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2,
  parameter int unsigned KEY_W = 8
) (
  input  logic [N-1:0]            match_i,
  input  logic [N-1:0][KEY_W-1:0] key_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [KEY_W-1:0] best;

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (match_i[i] && (!hit_o || key_i[i] < best)) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = key_i[i];
      end
    end
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = DEF_ENTRIES,
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned OFF_W       = DEF_OFF_W,
  parameter int unsigned TIME_W      = DEF_TIME_W,
  parameter int unsigned ORDER_W     = DEF_ORDER_W,
  localparam int unsigned IDX_W      = idx_width(NUM_ENTRIES),
  localparam int unsigned BLK_W      = ADDR_W - OFF_W,
  localparam int unsigned PKEY_W     = TIME_W + ORDER_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              alloc_secure_i,
  input  logic [TIME_W-1:0] alloc_ready_i,
  output logic              alloc_gnt_o,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  input  logic              lookup_secure_i,
  output logic              lookup_hit_o,
  output logic [IDX_W-1:0]  lookup_idx_o,
  input  logic [ADDR_W-1:0] pend_addr_i,
  input  logic              pend_secure_i,
  output logic              pend_hit_o,
  output logic [IDX_W-1:0]  pend_idx_o,
  input  logic              dealloc_valid_i,
  input  logic [IDX_W-1:0]  dealloc_idx_i,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_misalign_o,
  output logic              err_overflow_o
);
  logic [NUM_ENTRIES-1:0]              valid_q, valid_d;
  logic [NUM_ENTRIES-1:0][BLK_W-1:0]   blk_q;
  logic [NUM_ENTRIES-1:0]              sec_q;
  logic [NUM_ENTRIES-1:0][TIME_W-1:0]  rdy_q;
  logic [NUM_ENTRIES-1:0][ORDER_W-1:0] stamp_q;
  logic [ORDER_W-1:0]                  order_q;
  logic [TIME_W-1:0]                   now_q;
  logic                                misalign_q, overflow_q;

  logic                                free_any;
  logic [IDX_W-1:0]                    free_idx;
  logic                                aligned;
  logic [NUM_ENTRIES-1:0]              lk_match, pd_match;
  logic [NUM_ENTRIES-1:0][ORDER_W-1:0] lk_key;
  logic [NUM_ENTRIES-1:0][PKEY_W-1:0]  pd_key;

  assign aligned     = (alloc_addr_i[OFF_W-1:0] == '0);
  assign alloc_gnt_o = alloc_valid_i && aligned && free_any;
  assign alloc_idx_o = free_idx;

  mshr_free_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_free (
    .busy_i (valid_q),
    .found_o(free_any),
    .idx_o  (free_idx)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    logic [ORDER_W-1:0] age;
    // age grows with time since allocation; inverted so older sorts lower
    assign age         = order_q - stamp_q[g];
    assign lk_key[g]   = ~age;
    assign pd_key[g]   = {rdy_q[g], ~age};
    assign lk_match[g] = valid_q[g] && sec_q[g] == lookup_secure_i &&
                         blk_q[g] == lookup_addr_i[ADDR_W-1:OFF_W];
    assign pd_match[g] = valid_q[g] && sec_q[g] == pend_secure_i &&
                         blk_q[g] == pend_addr_i[ADDR_W-1:OFF_W] &&
                         now_q >= rdy_q[g];
  end

  mshr_oldest_sel #(.N(NUM_ENTRIES), .IDX_W(IDX_W), .KEY_W(ORDER_W)) u_lk_sel (
    .match_i(lk_match),
    .key_i  (lk_key),
    .hit_o  (lookup_hit_o),
    .idx_o  (lookup_idx_o)
  );

  mshr_oldest_sel #(.N(NUM_ENTRIES), .IDX_W(IDX_W), .KEY_W(PKEY_W)) u_pd_sel (
    .match_i(pd_match),
    .key_i  (pd_key),
    .hit_o  (pend_hit_o),
    .idx_o  (pend_idx_o)
  );

  always_comb begin
    valid_d = valid_q;
    if (dealloc_valid_i && 32'(dealloc_idx_i) < NUM_ENTRIES) valid_d[dealloc_idx_i] = 1'b0;
    if (alloc_gnt_o) valid_d[free_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      blk_q      <= '0;
      sec_q      <= '0;
      rdy_q      <= '0;
      stamp_q    <= '0;
      order_q    <= '0;
      now_q      <= '0;
      misalign_q <= 1'b0;
      overflow_q <= 1'b0;
    end else begin
      valid_q    <= valid_d;
      now_q      <= now_q + 1'b1;
      misalign_q <= alloc_valid_i && !aligned;
      overflow_q <= alloc_valid_i && aligned && !free_any && !dealloc_valid_i;
      if (alloc_gnt_o) begin
        blk_q[free_idx]   <= alloc_addr_i[ADDR_W-1:OFF_W];
        sec_q[free_idx]   <= alloc_secure_i;
        rdy_q[free_idx]   <= alloc_ready_i;
        stamp_q[free_idx] <= order_q;
        order_q           <= order_q + 1'b1;
      end
    end
  end

  assign full_o         = &valid_q;
  assign empty_o        = ~|valid_q;
  assign err_misalign_o = misalign_q;
  assign err_overflow_o = overflow_q;
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              alloc_valid_i,
  input logic [ADDR_W-1:0] alloc_addr_i,
  input logic              alloc_gnt_o,
  input logic [ADDR_W-1:0] lookup_addr_i,
  input logic              lookup_secure_i,
  input logic              lookup_hit_o,
  input logic [ADDR_W-1:0] pend_addr_i,
  input logic              pend_secure_i,
  input logic              pend_hit_o,
  input logic              dealloc_valid_i,
  input logic              full_o,
  input logic              empty_o,
  input logic              err_misalign_o,
  input logic              err_overflow_o
);
  p_gnt_not_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_gnt_o |-> !full_o);

  p_misalign_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_addr_i[OFF_W-1:0] != '0) |=> err_misalign_o);

  p_no_gnt_misalign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_gnt_o |-> alloc_addr_i[OFF_W-1:0] == '0);

  p_pend_sub_lookup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_hit_o && pend_secure_i == lookup_secure_i &&
     pend_addr_i[ADDR_W-1:OFF_W] == lookup_addr_i[ADDR_W-1:OFF_W]) |-> lookup_hit_o);

  p_full_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && dealloc_valid_i) |=> !full_o);

  p_overflow_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_addr_i[OFF_W-1:0] == '0 && full_o && !dealloc_valid_i)
    |=> err_overflow_o);

  p_quiet_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_valid_i |=> !err_overflow_o && !err_misalign_o);

  p_full_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

bind mshr_file mshr_file_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .alloc_valid_i  (alloc_valid_i),
  .alloc_addr_i   (alloc_addr_i),
  .alloc_gnt_o    (alloc_gnt_o),
  .lookup_addr_i  (lookup_addr_i),
  .lookup_secure_i(lookup_secure_i),
  .lookup_hit_o   (lookup_hit_o),
  .pend_addr_i    (pend_addr_i),
  .pend_secure_i  (pend_secure_i),
  .pend_hit_o     (pend_hit_o),
  .dealloc_valid_i(dealloc_valid_i),
  .full_o         (full_o),
  .empty_o        (empty_o),
  .err_misalign_o (err_misalign_o),
  .err_overflow_o (err_overflow_o)
);

// File: tb/mshr_file_bench.sv
`timescale 1ns/1ps
module mshr_file_bench;
  localparam logic [1:0] OP_ALLOC = 2'd0, OP_LOOK = 2'd1, OP_PEND = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic        sec;
    logic [15:0] rdy;
    logic        exp_hit;
    logic [1:0]  exp_idx;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{OP_ALLOC, 16'h1000, 1'b0, 16'h0000, 1'b1, 2'd0},  // R2
    '{OP_ALLOC, 16'h2000, 1'b1, 16'h0000, 1'b1, 2'd1},  // R2
    '{OP_ALLOC, 16'h1000, 1'b1, 16'hFFFF, 1'b1, 2'd2},  // R2
    '{OP_ALLOC, 16'h1000, 1'b0, 16'h0000, 1'b1, 2'd3},  // R2
    '{OP_LOOK,  16'h1008, 1'b0, 16'h0000, 1'b1, 2'd0},  // R4 R5
    '{OP_LOOK,  16'h1000, 1'b1, 16'h0000, 1'b1, 2'd2},  // R4
    '{OP_LOOK,  16'h2000, 1'b0, 16'h0000, 1'b0, 2'd0},  // R4
    '{OP_LOOK,  16'h3000, 1'b1, 16'h0000, 1'b0, 2'd0},  // R4
    '{OP_PEND,  16'h1000, 1'b1, 16'h0000, 1'b0, 2'd0},  // R6
    '{OP_PEND,  16'h1000, 1'b0, 16'h0000, 1'b1, 2'd0},  // R7
    '{OP_PEND,  16'h2004, 1'b1, 16'h0000, 1'b1, 2'd1},  // R7
    '{OP_ALLOC, 16'h4000, 1'b0, 16'h0000, 1'b0, 2'd0}   // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [15:0] alloc_addr = '0;
  logic        alloc_secure = 1'b0;
  logic [15:0] alloc_ready = '0;
  logic        alloc_gnt;
  logic [1:0]  alloc_idx;
  logic [15:0] lookup_addr = '0;
  logic        lookup_secure = 1'b0;
  logic        lookup_hit;
  logic [1:0]  lookup_idx;
  logic [15:0] pend_addr = '0;
  logic        pend_secure = 1'b0;
  logic        pend_hit;
  logic [1:0]  pend_idx;
  logic        dealloc_valid = 1'b0;
  logic [1:0]  dealloc_idx = '0;
  logic        full, empty, err_mis, err_ovf;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  mshr_file u_mshr_file (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_addr_i(alloc_addr),
    .alloc_secure_i(alloc_secure), .alloc_ready_i(alloc_ready),
    .alloc_gnt_o(alloc_gnt), .alloc_idx_o(alloc_idx),
    .lookup_addr_i(lookup_addr), .lookup_secure_i(lookup_secure),
    .lookup_hit_o(lookup_hit), .lookup_idx_o(lookup_idx),
    .pend_addr_i(pend_addr), .pend_secure_i(pend_secure),
    .pend_hit_o(pend_hit), .pend_idx_o(pend_idx),
    .dealloc_valid_i(dealloc_valid), .dealloc_idx_i(dealloc_idx),
    .full_o(full), .empty_o(empty),
    .err_misalign_o(err_mis), .err_overflow_o(err_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 1'b0; dealloc_valid = 1'b0;
  endtask

  task automatic do_alloc(input logic [15:0] a, input logic s, input logic [15:0] r);
    @(negedge clk); idle();
    alloc_valid = 1'b1; alloc_addr = a; alloc_secure = s; alloc_ready = r;
    #1;
  endtask

  task automatic do_dealloc(input logic [1:0] i);
    @(negedge clk); idle();
    dealloc_valid = 1'b1; dealloc_idx = i;
  endtask

  task automatic settle();
    @(negedge clk); idle(); #1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 lookup", lookup_hit, 0); chk("R1 pend", pend_hit, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk); idle();
      case (VECS[i].op)
        OP_ALLOC: begin
          alloc_valid = 1'b1; alloc_addr = VECS[i].addr;
          alloc_secure = VECS[i].sec; alloc_ready = VECS[i].rdy;
          #1;
          chk($sformatf("R2/R9 vec%0d gnt", i), alloc_gnt, VECS[i].exp_hit);
          if (VECS[i].exp_hit) chk($sformatf("R2 vec%0d idx", i), alloc_idx, VECS[i].exp_idx);
        end
        OP_LOOK: begin
          lookup_addr = VECS[i].addr; lookup_secure = VECS[i].sec;
          #1;
          chk($sformatf("R4 vec%0d hit", i), lookup_hit, VECS[i].exp_hit);
          if (VECS[i].exp_hit) chk($sformatf("R5 vec%0d idx", i), lookup_idx, VECS[i].exp_idx);
        end
        default: begin
          pend_addr = VECS[i].addr; pend_secure = VECS[i].sec;
          #1;
          chk($sformatf("R6 vec%0d hit", i), pend_hit, VECS[i].exp_hit);
          if (VECS[i].exp_hit) chk($sformatf("R7 vec%0d idx", i), pend_idx, VECS[i].exp_idx);
        end
      endcase
    end

    settle();
    chk("R9 overflow err", err_ovf, 1);
    chk("R10 full", full, 1);
    chk("R10 not empty", empty, 0);

    // release and allocate together on a full pool
    do_alloc(16'h5000, 1'b0, 16'h0000);
    dealloc_valid = 1'b1; dealloc_idx = 2'd0;
    #1;
    chk("R9 no gnt while full", alloc_gnt, 0);
    settle();
    chk("R9 no err with dealloc", err_ovf, 0);
    chk("R8 full drops", full, 0);
    lookup_addr = 16'h1000; lookup_secure = 1'b0; #1;
    chk("R8 freed gone", lookup_idx, 3);

    do_alloc(16'h5000, 1'b0, 16'h0000);
    chk("R8 reuse gnt", alloc_gnt, 1);
    chk("R8 reuse idx", alloc_idx, 0);

    do_dealloc(2'd1);
    do_dealloc(2'd3);
    do_alloc(16'h6000, 1'b0, 16'(cyc + 30));
    chk("R2 idx1", alloc_idx, 1);
    do_alloc(16'h6000, 1'b0, 16'd2);
    chk("R2 idx3", alloc_idx, 3);
    settle();
    pend_addr = 16'h6000; pend_secure = 1'b0;
    lookup_addr = 16'h6000; lookup_secure = 1'b0; #1;
    chk("R7 earliest ready hit", pend_hit, 1);
    chk("R7 earliest ready idx", pend_idx, 3);
    chk("R5 oldest idx", lookup_idx, 1);

    do_dealloc(2'd3);
    settle();
    chk("R6 not yet ready", pend_hit, 0);
    chk("R6 lookup still sees it", lookup_hit, 1);
    repeat (40) @(negedge clk);
    #1;
    chk("R6 now ready", pend_hit, 1);
    chk("R6 ready idx", pend_idx, 1);

    do_alloc(16'h7004, 1'b0, 16'h0000);
    chk("R3 refused", alloc_gnt, 0);
    settle();
    chk("R3 err pulse", err_mis, 1);
    lookup_addr = 16'h7000; #1;
    chk("R3 not stored", lookup_hit, 0);
    settle();
    chk("R3 err clears", err_mis, 0);

    do_dealloc(2'd0);
    do_dealloc(2'd1);
    do_dealloc(2'd2);
    settle();
    chk("R10 empty", empty, 1);
    lookup_addr = 16'h1000; lookup_secure = 1'b1; #1;
    chk("R8 all released", lookup_hit, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule